// File: doc/BRIEF.md
# Vector Block Context Register and Sequencer

This block holds the architectural context of a vector instruction block while a processor runs through it. A four-state sequencer, shown in the top two bits of a 32-bit control register, follows the decode front end. The states are SCALAR (00, ordinary scalar execution), HDR (01, header fields captured), TBL (10, length setup done, predicate/register/swizzle tables being loaded) and RUN (11, tables loaded, opcodes executing). The block also keeps the captured header fields, an optional 16-bit second header word and a 5-bit in-block opcode pointer. The pointer counts in 16-bit units from the first opcode.

The named transitions are: SCALAR→HDR on a detected header (capture); HDR→TBL once the length block is actioned (a one-cycle SETVL request follows); TBL→RUN when the tables are loaded; RUN→TBL on a trap return (reload, pointer kept); RUN→SCALAR when the last instruction retires (context clear). A CSR port takes immediate-form and register-form writes of the pointer. A write is legal only in RUN and only below the block's opcode length. A legal write moves the pointer and sends a jump request to fetch. Any other write raises an illegal-instruction flag and changes nothing.

Top module: `vblk_ctx_ctrl`

## Requirements
- R1: After reset, status is SCALAR (00), every register field reads zero, and setvl_req, ctx_clear, illegal_insn and jump_req are low.
- R2: Only hdr_valid leaves SCALAR (to HDR). In that cycle vlset, the 3-bit width field, pplen, rplen and mode are captured and opptr is set to 0. The 16-bit second word is captured only when the width field is 3'b111; otherwise it is 0. hdr_valid in any other state has no effect.
- R3: In HDR, len_done moves to TBL, and setvl_req is high for exactly the one cycle after that edge.
- R4: In TBL, tbl_done moves to RUN. A trap_ret in TBL leaves the state at TBL.
- R5: In RUN with no write, trap or last retire, ins_ret adds ins_len (in 16-bit units) to opptr.
- R6: An immediate-form write (csr_wr_imm) in RUN takes csr_wdata[4:0], zero-extended, as the target. If the target is below blk_len, opptr takes it and jump_req pulses for one cycle, with jump_ptr equal to the target.
- R7: A register-form write (csr_wr_reg) compares all 32 bits of csr_wdata against blk_len. Otherwise it follows the rules of R6. If both forms are requested together, the immediate form is used.
- R8: A write in RUN whose target is not below blk_len pulses illegal_insn for one cycle and leaves opptr and status unchanged.
- R9: Any write while status is not RUN pulses illegal_insn and leaves all register fields and status unchanged.
- R10: trap_ret in RUN (with no legal write in that cycle) moves to TBL and keeps opptr. A later tbl_done returns to RUN with the same opptr.
- R11: last_retire in RUN with no legal write or trap in the same cycle moves to SCALAR, clears all fields and pulses ctx_clear for one cycle. A legal write in the same cycle takes priority, and the block stays in RUN.
- R12: csr_rdata always reads status[31:30], vlset[29], width[28:26], pplen[25:24], rplen[23:22], mode[21], second word[20:5], opptr[4:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Start of a valid vector block header seen |
| hdr_vlset | input | 1 | Header length-setup flag |
| hdr_xil | input | 3 | Header width field; 3'b111 marks a second word |
| hdr_pplen | input | 2 | Header predicate table length |
| hdr_rplen | input | 2 | Header register table length |
| hdr_mode | input | 1 | Header mode bit |
| hdr_word2 | input | 16 | Second header word |
| len_done | input | 1 | Length block actioned |
| tbl_done | input | 1 | Predicate and register tables loaded |
| trap_ret | input | 1 | Return from trap |
| last_retire | input | 1 | Last block instruction retired |
| ins_ret | input | 1 | Block instruction retired |
| ins_len | input | 2 | Size of retired instruction in 16-bit units |
| blk_len | input | 6 | Opcode length of block in 16-bit units |
| csr_wr_imm | input | 1 | Immediate-form pointer write |
| csr_wr_reg | input | 1 | Register-form pointer write |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Full register value |
| setvl_req | output | 1 | One-cycle SETVL request |
| ctx_clear | output | 1 | One-cycle vector context clear |
| illegal_insn | output | 1 | One-cycle illegal-instruction flag |
| jump_req | output | 1 | One-cycle in-block jump request |
| jump_ptr | output | 5 | Jump target (current opptr) |

## Verification
The hardest cases to reach are the ones that need the sequencer deep in RUN with a non-zero pointer and then two events in the same cycle. Examples are a last retire together with a legal write, and a register write whose low five bits are in range while its upper bits are not. The stimulus table walks the block through header, length, tables and several retires first. It then applies these collisions and the trap-return reload while a known pointer is held. Directed tests cover header capture with and without the second word, a header pulse ignored outside SCALAR, and reset in mid-block.

// File: rtl/vblk_pkg.sv
package vblk_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned PTR_W  = 5;
    localparam int unsigned W2_W   = 16;
    localparam int unsigned XIL_W  = 3;
    localparam int unsigned PLEN_W = 2;
    localparam int unsigned INS_W  = 2;

    localparam logic [XIL_W-1:0] XIL_WIDE = 3'b111;

    typedef enum logic [1:0] {
        ST_SCALAR = 2'b00,
        ST_HDR    = 2'b01,
        ST_TBL    = 2'b10,
        ST_RUN    = 2'b11
    } vstate_e;

    typedef struct packed {
        logic              vlset;
        logic [XIL_W-1:0]  xil;
        logic [PLEN_W-1:0] pplen;
        logic [PLEN_W-1:0] rplen;
        logic              mode;
    } hdr_t;

endpackage

// File: rtl/vblk_wr_chk.sv
module vblk_wr_chk
    import vblk_pkg::*;
#(
    parameter int unsigned LEN_W = 6
) (
    input  vstate_e             state,
    input  logic                wr_imm,
    input  logic                wr_reg,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [LEN_W-1:0]    blk_len,
    output logic                wr_ok,
    output logic                wr_bad,
    output logic [PTR_W-1:0]    wr_ptr
);

    logic [DATA_W-1:0] target;
    logic              wr_any;
    logic              in_range;

    always_comb begin
        if (wr_imm) begin
            target = {{(DATA_W-PTR_W){1'b0}}, wdata[PTR_W-1:0]};
        end else begin
            target = wdata;
        end
        wr_any   = wr_imm | wr_reg;
        in_range = target < DATA_W'(blk_len);
        wr_ok    = wr_any && (state == ST_RUN) && in_range;
        wr_bad   = wr_any && !wr_ok;
        wr_ptr   = target[PTR_W-1:0];
    end

endmodule

// File: rtl/vblk_seq.sv
module vblk_seq
    import vblk_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    hdr_valid,
    input  logic    len_done,
    input  logic    tbl_done,
    input  logic    trap_ret,
    input  logic    last_retire,
    input  logic    ins_ret,
    input  logic    wr_ok,
    input  logic    wr_bad,
    output vstate_e state,
    output logic    cap_hdr,
    output logic    clr_all,
    output logic    set_ptr,
    output logic    step_ptr,
    output logic    setvl_req,
    output logic    ctx_clear,
    output logic    illegal_insn,
    output logic    jump_req
);

    vstate_e state_nxt;
    logic    go_setvl;

    // next state and strobes
    always_comb begin
        state_nxt = state;
        cap_hdr   = 1'b0;
        clr_all   = 1'b0;
        set_ptr   = 1'b0;
        step_ptr  = 1'b0;
        go_setvl  = 1'b0;
        unique case (state)
            ST_SCALAR: begin
                if (hdr_valid) begin
                    state_nxt = ST_HDR;
                    cap_hdr   = 1'b1;
                end
            end
            ST_HDR: begin
                if (len_done) begin
                    state_nxt = ST_TBL;
                    go_setvl  = 1'b1;
                end
            end
            ST_TBL: begin
                if (tbl_done) begin
                    state_nxt = ST_RUN;
                end
            end
            ST_RUN: begin
                if (wr_ok) begin
                    set_ptr = 1'b1;
                end else if (trap_ret) begin
                    state_nxt = ST_TBL;
                end else if (last_retire) begin
                    state_nxt = ST_SCALAR;
                    clr_all   = 1'b1;
                end else if (ins_ret) begin
                    step_ptr = 1'b1;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_SCALAR;
        end else begin
            state <= state_nxt;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setvl_req    <= 1'b0;
            ctx_clear    <= 1'b0;
            illegal_insn <= 1'b0;
            jump_req     <= 1'b0;
        end else begin
            setvl_req    <= go_setvl;
            ctx_clear    <= clr_all;
            illegal_insn <= wr_bad;
            jump_req     <= wr_ok;
        end
    end

    // R3
    setvl_from_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        setvl_req |-> (state == ST_TBL) && ($past(state) == ST_HDR));

    // R2
    leave_scalar_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_SCALAR) && (state != ST_SCALAR) |-> $past(hdr_valid));

    // R11
    clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_clear |-> (state == ST_SCALAR) && ($past(state) == ST_RUN));

    // R6
    jump_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jump_req |-> (state == ST_RUN) && !illegal_insn);

    // R4
    trap_tbl_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TBL) && trap_ret && !tbl_done |=> (state == ST_TBL));

endmodule

// File: rtl/vblk_fields.sv
module vblk_fields
    import vblk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_hdr,
    input  logic              clr_all,
    input  logic              set_ptr,
    input  logic              step_ptr,
    input  hdr_t              hdr_in,
    input  logic [W2_W-1:0]   word2_in,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [INS_W-1:0]  ins_len,
    output hdr_t              hdr_q,
    output logic [W2_W-1:0]   word2_q,
    output logic [PTR_W-1:0]  opptr_q
);

    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            hdr_q   <= '0;
            word2_q <= '0;
            opptr_q <= '0;
        end else if (cap_hdr) begin
            hdr_q   <= hdr_in;
            word2_q <= (hdr_in.xil == XIL_WIDE) ? word2_in : '0;
            opptr_q <= '0;
        end else if (set_ptr) begin
            opptr_q <= wr_ptr;
        end else if (step_ptr) begin
            opptr_q <= opptr_q + PTR_W'(ins_len);
        end
    end

endmodule

// File: rtl/vblk_ctx_ctrl.sv
module vblk_ctx_ctrl
    import vblk_pkg::*;
#(
    parameter int unsigned LEN_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hdr_valid,
    input  logic               hdr_vlset,
    input  logic [2:0]         hdr_xil,
    input  logic [1:0]         hdr_pplen,
    input  logic [1:0]         hdr_rplen,
    input  logic               hdr_mode,
    input  logic [15:0]        hdr_word2,
    input  logic               len_done,
    input  logic               tbl_done,
    input  logic               trap_ret,
    input  logic               last_retire,
    input  logic               ins_ret,
    input  logic [1:0]         ins_len,
    input  logic [LEN_W-1:0]   blk_len,
    input  logic               csr_wr_imm,
    input  logic               csr_wr_reg,
    input  logic [31:0]        csr_wdata,
    output logic [31:0]        csr_rdata,
    output logic               setvl_req,
    output logic               ctx_clear,
    output logic               illegal_insn,
    output logic               jump_req,
    output logic [4:0]         jump_ptr
);

    vstate_e           state;
    logic              cap_hdr, clr_all, set_ptr, step_ptr;
    logic              wr_ok, wr_bad;
    logic [PTR_W-1:0]  wr_ptr;
    hdr_t              hdr_in, hdr_q;
    logic [W2_W-1:0]   word2_q;
    logic [PTR_W-1:0]  opptr_q;

    assign hdr_in = '{vlset: hdr_vlset, xil: hdr_xil, pplen: hdr_pplen,
                      rplen: hdr_rplen, mode: hdr_mode};

    vblk_wr_chk #(.LEN_W(LEN_W)) u_wr_chk (
        .state   (state),
        .wr_imm  (csr_wr_imm),
        .wr_reg  (csr_wr_reg),
        .wdata   (csr_wdata),
        .blk_len (blk_len),
        .wr_ok   (wr_ok),
        .wr_bad  (wr_bad),
        .wr_ptr  (wr_ptr)
    );

    vblk_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .hdr_valid    (hdr_valid),
        .len_done     (len_done),
        .tbl_done     (tbl_done),
        .trap_ret     (trap_ret),
        .last_retire  (last_retire),
        .ins_ret      (ins_ret),
        .wr_ok        (wr_ok),
        .wr_bad       (wr_bad),
        .state        (state),
        .cap_hdr      (cap_hdr),
        .clr_all      (clr_all),
        .set_ptr      (set_ptr),
        .step_ptr     (step_ptr),
        .setvl_req    (setvl_req),
        .ctx_clear    (ctx_clear),
        .illegal_insn (illegal_insn),
        .jump_req     (jump_req)
    );

    vblk_fields u_fields (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_hdr  (cap_hdr),
        .clr_all  (clr_all),
        .set_ptr  (set_ptr),
        .step_ptr (step_ptr),
        .hdr_in   (hdr_in),
        .word2_in (hdr_word2),
        .wr_ptr   (wr_ptr),
        .ins_len  (ins_len),
        .hdr_q    (hdr_q),
        .word2_q  (word2_q),
        .opptr_q  (opptr_q)
    );

    assign csr_rdata = {state, hdr_q.vlset, hdr_q.xil, hdr_q.pplen, hdr_q.rplen,
                        hdr_q.mode, word2_q, opptr_q};
    assign jump_ptr  = opptr_q;

    // R10
    trap_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_RUN) && (state == ST_TBL) |-> (opptr_q == $past(opptr_q)));

    // R9
    bad_write_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN) && (csr_wr_imm || csr_wr_reg) && !hdr_valid && !len_done
            && !tbl_done |=> illegal_insn && $stable(csr_rdata));

    // R8
    range_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jump_req |-> (32'(jump_ptr) < 32'($past(blk_len))));

    // R12
    status_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[31:30] == 2'(state));

endmodule

// File: tb/vblk_ctx_ctrl_bench.sv
`timescale 1ns/1ps
module vblk_ctx_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_valid = 0, hdr_vlset = 0, hdr_mode = 0;
    logic [2:0]  hdr_xil = 0;
    logic [1:0]  hdr_pplen = 0, hdr_rplen = 0, ins_len = 0;
    logic [15:0] hdr_word2 = 0;
    logic        len_done = 0, tbl_done = 0, trap_ret = 0, last_retire = 0, ins_ret = 0;
    logic [5:0]  blk_len = 6'd10;
    logic        csr_wr_imm = 0, csr_wr_reg = 0;
    logic [31:0] csr_wdata = 0;
    logic [31:0] csr_rdata;
    logic        setvl_req, ctx_clear, illegal_insn, jump_req;
    logic [4:0]  jump_ptr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    vblk_ctx_ctrl u_vblk_ctx_ctrl (
        .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_vlset(hdr_vlset),
        .hdr_xil(hdr_xil), .hdr_pplen(hdr_pplen), .hdr_rplen(hdr_rplen),
        .hdr_mode(hdr_mode), .hdr_word2(hdr_word2), .len_done(len_done),
        .tbl_done(tbl_done), .trap_ret(trap_ret), .last_retire(last_retire),
        .ins_ret(ins_ret), .ins_len(ins_len), .blk_len(blk_len),
        .csr_wr_imm(csr_wr_imm), .csr_wr_reg(csr_wr_reg), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .setvl_req(setvl_req), .ctx_clear(ctx_clear),
        .illegal_insn(illegal_insn), .jump_req(jump_req), .jump_ptr(jump_ptr)
    );

    // ev bits: 7 hdr, 6 len, 5 tbl, 4 trap, 3 last, 2 ins, 1 wimm, 0 wreg
    typedef struct packed {
        logic [7:0]  ev;
        logic [1:0]  ilen;
        logic [31:0] wd;
        logic [1:0]  st;
        logic        ill;
        logic        jmp;
        logic        svl;
        logic        clr;
        logic [4:0]  ptr;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{8'h02, 2'd0, 32'd3,          2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0}, // R9
        '{8'h80, 2'd0, 32'd0,          2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0}, // R2
        '{8'h01, 2'd0, 32'd2,          2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0}, // R9
        '{8'h40, 2'd0, 32'd0,          2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0}, // R3
        '{8'h00, 2'd0, 32'd0,          2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0}, // R3
        '{8'h20, 2'd0, 32'd0,          2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0}, // R4
        '{8'h04, 2'd2, 32'd0,          2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 5'd2}, // R5
        '{8'h04, 2'd1, 32'd0,          2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 5'd3}, // R5
        '{8'h02, 2'd0, 32'd7,          2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 5'd7}, // R6
        '{8'h02, 2'd0, 32'd10,         2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 5'd7}, // R8
        '{8'h01, 2'd0, 32'h0000_0025,  2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 5'd7}, // R7
        '{8'h01, 2'd0, 32'd9,          2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 5'd9}, // R7
        '{8'h02, 2'd0, 32'hFFFF_FFE4,  2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 5'd4}, // R6
        '{8'h03, 2'd0, 32'h0000_0022,  2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 5'd2}, // R7
        '{8'h10, 2'd0, 32'd0,          2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 5'd2}, // R10
        '{8'h10, 2'd0, 32'd0,          2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 5'd2}, // R4
        '{8'h20, 2'd0, 32'd0,          2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 5'd2}, // R10
        '{8'h0A, 2'd0, 32'd1,          2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 5'd1}, // R11
        '{8'h08, 2'd0, 32'd0,          2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0}, // R11
        '{8'h10, 2'd0, 32'd0,          2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0}  // R1
    };

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        hdr_valid = 0; len_done = 0; tbl_done = 0; trap_ret = 0; last_retire = 0;
        ins_ret = 0; ins_len = 0; csr_wr_imm = 0; csr_wr_reg = 0; csr_wdata = 0;
    endtask

    task automatic set_hdr(input logic v, input logic [2:0] x, input logic [1:0] p,
                           input logic [1:0] r, input logic m, input logic [15:0] w);
        hdr_vlset = v; hdr_xil = x; hdr_pplen = p; hdr_rplen = r; hdr_mode = m; hdr_word2 = w;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 0;
        step(); step();
        rst_n = 1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp_w;
        do_reset();
        step();
        // R1: reset state
        check32("R1", csr_rdata, 32'h0);
        check32("R1", {28'h0, setvl_req, ctx_clear, illegal_insn, jump_req}, 32'h0);

        set_hdr(1'b0, 3'b010, 2'b01, 2'b10, 1'b0, 16'h1234);
        for (int i = 0; i < NV; i++) begin
            idle_inputs();
            hdr_valid   = VEC[i].ev[7];
            len_done    = VEC[i].ev[6];
            tbl_done    = VEC[i].ev[5];
            trap_ret    = VEC[i].ev[4];
            last_retire = VEC[i].ev[3];
            ins_ret     = VEC[i].ev[2];
            csr_wr_imm  = VEC[i].ev[1];
            csr_wr_reg  = VEC[i].ev[0];
            ins_len     = VEC[i].ilen;
            csr_wdata   = VEC[i].wd;
            step();
            check32($sformatf("vector %0d R2-R11 path", i),
                {19'h0, csr_rdata[31:30], illegal_insn, jump_req, setvl_req, ctx_clear, csr_rdata[4:0]},
                {19'h0, VEC[i].st, VEC[i].ill, VEC[i].jmp, VEC[i].svl, VEC[i].clr, VEC[i].ptr});
            if (VEC[i].jmp) check32("R6 jump_ptr", {27'h0, jump_ptr}, {27'h0, VEC[i].ptr});
        end
        // R11: fields cleared after exit
        check32("R11 cleared", csr_rdata, 32'h0);

        // R2 and R12: header with second word
        idle_inputs();
        set_hdr(1'b1, 3'b111, 2'b10, 2'b01, 1'b1, 16'hBEEF);
        hdr_valid = 1;
        step();
        exp_w = {2'b01, 1'b1, 3'b111, 2'b10, 2'b01, 1'b1, 16'hBEEF, 5'd0};
        check32("R12 layout", csr_rdata, exp_w);

        // R2: header pulse in HDR ignored
        set_hdr(1'b0, 3'b000, 2'b00, 2'b00, 1'b0, 16'h0000);
        hdr_valid = 1;
        step();
        check32("R2 ignored", csr_rdata, exp_w);

        // R1: reset mid block
        do_reset();
        step();
        check32("R1 mid-block reset", csr_rdata, 32'h0);

        // R2: narrow header drops second word
        set_hdr(1'b0, 3'b011, 2'b11, 2'b11, 1'b0, 16'hCAFE);
        hdr_valid = 1;
        step();
        idle_inputs();
        check32("R2 no word2", csr_rdata, {2'b01, 1'b0, 3'b011, 2'b11, 2'b11, 1'b0, 16'h0, 5'd0});

        // R9: write in TBL frozen
        len_done = 1; step(); idle_inputs();
        exp_w = csr_rdata;
        csr_wr_imm = 1; csr_wdata = 32'd1;
        step(); idle_inputs();
        check32("R9 TBL write", {csr_rdata[31:1], illegal_insn}, {exp_w[31:1], 1'b1});
        step();
        check32("R9 pulse one cycle", {31'h0, illegal_insn}, 32'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule